// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is the slave end of a four-wire serial link. Through it a host reads and writes a bank of 16-bit configuration words. The host lowers an active-low select, `cs_n`, and then clocks one fixed 24-bit frame on `sclk`. The frame opens with a 7-bit word address and a one-bit direction flag. Sixteen data bits follow. Address and data are both sent most significant bit first.

The slave samples `sdin` on each falling edge of `sclk` and changes `sdout` on each rising edge. The host therefore reads `sdout` on the falling edge, the same edge on which the slave samples `sdin`.

The bit counter and the shift registers clear asynchronously whenever `cs_n` is high. Every frame therefore starts from a clean state. A write reaches the register bank only when all 24 bits arrive inside one select window. A frame that is cut short has no effect. The bank depth is the parameter `NUM_REGS`, which defaults to 32 words. Addresses at or above the depth read as zero and ignore writes.

Top module: `spi_cfg_slave`

## Requirements
- R1: A frame is 7 address bits (MSB first), then a direction bit (1 = read, 0 = write), then 16 data bits (MSB first). `sdin` is sampled on the falling edge of `sclk`.
- R2: A write frame of 24 clocks stores its 16 data bits in the addressed word. The store happens at the 24th falling edge.
- R3: In a read frame, `sdout` carries D15 through D0 of the addressed word on clocks 9 to 24. Each bit changes on the rising edge and is valid at the following falling edge.
- R4: `sdout` stays low during the 8 header clocks of every frame and for the whole of a write frame.
- R5: `sdout` is low whenever `cs_n` is high, including right after a read frame that ended early.
- R6: A frame with fewer than 24 clocks leaves every word unchanged.
- R7: Clocks beyond the 24th in one frame are ignored. No second write occurs and the stored word keeps the frame's data.
- R8: Driving `rst_n` low clears every word to 0.
- R9: Addresses at or above `NUM_REGS` read as 0, and writes to them change no word.
- R10: Raising `cs_n` resets the bit position. A full frame after an aborted one is decoded from its first bit.
- R11: A read frame never modifies the addressed word, whatever `sdin` carries during its data phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset of the register bank |
| cs_n | input | 1 | Active-low frame select; high clears the frame logic |
| sclk | input | 1 | Serial clock from the host |
| sdin | input | 1 | Serial data from the host, sampled on falling edges |
| sdout | output | 1 | Serial read data, changed on rising edges, low when idle |

## Verification
Write and read frames are tried with the data words A5C3, FFFF, 0001 and 8000. Each lands at a different address, including the lowest and the highest valid one. This separates bit-order and MSB/LSB slips from address-decode faults.

Three frame-length cases separate a commit on the wrong edge from a correct one:
- a frame one bit short;
- a frame six clocks too long;
- a read frame aborted mid-data.

A read frame that carries all-ones data shows whether the direction bit really gates writes. An out-of-range address whose low bits alias a valid word shows whether decoding uses the full address.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
  localparam int ADDR_W  = 7;
  localparam int DATA_W  = 16;
  localparam int HDR_W   = ADDR_W + 1;
  localparam int FRAME_W = HDR_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] word_t;

  localparam logic DIR_READ = 1'b1;
endpackage

// File: rtl/spi_cfg_rx.sv
module spi_cfg_rx
  import spi_cfg_pkg::*;
(
  input  logic                sclk,
  input  logic                clr,
  input  logic                sdin,
  output cnt_t                cnt,
  output addr_t               hdr_addr,
  output logic                hdr_dir,
  output logic                wr_stb,
  output addr_t               wr_addr,
  output word_t               wr_data
);
  localparam cnt_t LAST = cnt_t'(FRAME_W);
  localparam cnt_t PRE  = cnt_t'(FRAME_W - 1);

  logic [FRAME_W-1:0] sreg_q, sreg_d;
  cnt_t               cnt_q, cnt_d;
  logic               take;

  always_comb begin
    take   = (cnt_q != LAST);
    cnt_d  = cnt_q;
    sreg_d = sreg_q;
    if (take) begin
      cnt_d  = cnt_q + cnt_t'(1);
      sreg_d = {sreg_q[FRAME_W-2:0], sdin};
    end
  end

  always_ff @(negedge sclk or posedge clr) begin
    if (clr) begin
      cnt_q  <= '0;
      sreg_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      sreg_q <= sreg_d;
    end
  end

  assign cnt      = cnt_q;
  assign hdr_addr = sreg_q[HDR_W-1:1];
  assign hdr_dir  = sreg_q[0];
  // At count FRAME_W-1 the register holds address, direction and D15..D1.
  assign wr_stb   = (cnt_q == PRE) && (sreg_q[DATA_W-1] != DIR_READ);
  assign wr_addr  = sreg_q[FRAME_W-2:DATA_W];
  assign wr_data  = {sreg_q[DATA_W-2:0], sdin};
endmodule

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs
  import spi_cfg_pkg::*;
#(
  parameter int NUM_REGS = 32
) (
  input  logic  sclk,
  input  logic  rst_n,
  input  logic  wr_stb,
  input  addr_t wr_addr,
  input  word_t wr_data,
  input  addr_t rd_addr,
  output word_t rd_data
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  word_t mem_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
    word_t q;
    logic  en;
    assign en = wr_stb && (wr_addr == addr_t'(g));
    always_ff @(negedge sclk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= wr_data;
    end
    assign mem_q[g] = q;
  end

  logic             rd_ok;
  logic [IDX_W-1:0] rd_idx;

  always_comb begin
    rd_ok   = (int'(rd_addr) < NUM_REGS);
    rd_idx  = rd_addr[IDX_W-1:0];
    rd_data = rd_ok ? mem_q[rd_idx] : '0;
  end
endmodule

// File: rtl/spi_cfg_tx.sv
module spi_cfg_tx
  import spi_cfg_pkg::*;
(
  input  logic  sclk,
  input  logic  clr,
  input  cnt_t  cnt,
  input  logic  hdr_dir,
  input  word_t rd_data,
  output logic  oe,
  output logic  sdout
);
  word_t tx_q, tx_d;
  logic  oe_q, oe_d;
  logic  load;

  always_comb begin
    load = (cnt == cnt_t'(HDR_W)) && (hdr_dir == DIR_READ) && !oe_q;
    oe_d = oe_q | load;
    tx_d = tx_q;
    if (load)      tx_d = rd_data;
    else if (oe_q) tx_d = {tx_q[DATA_W-2:0], 1'b0};
  end

  always_ff @(posedge sclk or posedge clr) begin
    if (clr) begin
      oe_q <= 1'b0;
      tx_q <= '0;
    end else begin
      oe_q <= oe_d;
      tx_q <= tx_d;
    end
  end

  assign oe    = oe_q;
  assign sdout = oe_q & tx_q[DATA_W-1];
endmodule

// File: rtl/spi_cfg_slave.sv
module spi_cfg_slave
  import spi_cfg_pkg::*;
#(
  parameter int NUM_REGS = 32
) (
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic sdin,
  output logic sdout
);
  logic  clr;
  cnt_t  cnt;
  addr_t hdr_addr;
  logic  hdr_dir;
  logic  wr_stb;
  addr_t wr_addr;
  word_t wr_data;
  word_t rd_data;
  logic  tx_oe;

  assign clr = cs_n | ~rst_n;

  spi_cfg_rx u_rx (
    .sclk(sclk), .clr(clr), .sdin(sdin), .cnt(cnt),
    .hdr_addr(hdr_addr), .hdr_dir(hdr_dir),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  spi_cfg_regs #(.NUM_REGS(NUM_REGS)) u_regs (
    .sclk(sclk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(hdr_addr), .rd_data(rd_data)
  );

  spi_cfg_tx u_tx (
    .sclk(sclk), .clr(clr), .cnt(cnt), .hdr_dir(hdr_dir),
    .rd_data(rd_data), .oe(tx_oe), .sdout(sdout)
  );
endmodule

// File: rtl/spi_cfg_slave_chk.sv
module spi_cfg_slave_chk
  import spi_cfg_pkg::*;
(
  input logic rst_n,
  input logic cs_n,
  input logic sclk,
  input logic sdout,
  input cnt_t cnt,
  input logic oe,
  input logic wr_stb
);
  // R1
  cnt_limit_chk: assert property (@(negedge sclk) disable iff (!rst_n || cs_n)
    int'(cnt) <= FRAME_W);

  // R4
  hdr_quiet_chk: assert property (@(negedge sclk) disable iff (!rst_n || cs_n)
    (int'(cnt) < HDR_W) |-> !sdout);

  // R3
  oe_after_hdr_chk: assert property (@(negedge sclk) disable iff (!rst_n || cs_n)
    oe |-> (int'(cnt) >= HDR_W));

  // R2
  wr_last_bit_chk: assert property (@(negedge sclk) disable iff (!rst_n)
    wr_stb |-> (!cs_n && int'(cnt) == FRAME_W - 1));

  // R11
  no_wr_on_read_chk: assert property (@(negedge sclk) disable iff (!rst_n || cs_n)
    oe |-> !wr_stb);
endmodule

bind spi_cfg_slave spi_cfg_slave_chk u_chk (
  .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdout(sdout),
  .cnt(cnt), .oe(tx_oe), .wr_stb(wr_stb)
);

// File: tb/spi_cfg_slave_bench.sv
`timescale 1ns/1ps
module spi_cfg_slave_bench;
  logic clk = 1'b0;
  logic rst_n, cs_n, sclk, sdin;
  logic sdout;
  int   errors = 0;
  int   checks = 0;
  int   cyc    = 0;

  always #10 clk = ~clk;

  spi_cfg_slave #(.NUM_REGS(32)) u_spi_cfg_slave (
    .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdin(sdin), .sdout(sdout)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog expired (all requirements): actual hung, expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check16(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One frame of nclk clocks; returns the data-phase read bits and whether sdout was high in the header.
  task automatic xfer(input logic [6:0] a, input logic dir, input logic [15:0] d,
                      input int nclk, output logic [15:0] rd, output logic hdr_hi,
                      input bit keep_cs = 1'b0);
    logic [23:0] f;
    f = {a, dir, d};
    rd = '0;
    hdr_hi = 1'b0;
    cs_n = 1'b0;
    #25;
    for (int k = 1; k <= nclk; k++) begin
      sclk = 1'b1;
      sdin = (k <= 24) ? f[24-k] : 1'b1;
      #24;
      if (k >= 9 && k <= 24) rd[24-k] = sdout;
      else if (k <= 8 && sdout) hdr_hi = 1'b1;
      #1 sclk = 1'b0;
      #25;
    end
    if (!keep_cs) begin
      cs_n = 1'b1;
      #60;
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [15:0] d);
    logic [15:0] rd;
    logic h;
    xfer(a, 1'b0, d, 24, rd, h);
    check16("R4 write-frame sdout", {15'd0, h | (|rd)}, 16'd0);
  endtask

  task automatic rd_chk(input string req, input logic [6:0] a, input logic [15:0] exp);
    logic [15:0] rd;
    logic h;
    xfer(a, 1'b1, 16'h0000, 24, rd, h);
    check16(req, rd, exp);
    check16("R4 header sdout", {15'd0, h}, 16'd0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; #45; rst_n = 1'b1; #40;
    check16("R5 idle sdout", {15'd0, sdout}, 16'd0);
    rd_chk("R8 reset word 0", 7'd0, 16'h0000);
    rd_chk("R8 reset word 5", 7'd5, 16'h0000);
  endtask

  task automatic t_patterns;
    wr(7'd3, 16'hA5C3);
    wr(7'd0, 16'hFFFF);
    wr(7'd31, 16'h0001);
    wr(7'd17, 16'h8000);
    rd_chk("R1 R2 R3 word 3", 7'd3, 16'hA5C3);
    rd_chk("R2 R3 word 0", 7'd0, 16'hFFFF);
    rd_chk("R2 R3 word 31", 7'd31, 16'h0001);
    rd_chk("R1 R3 word 17", 7'd17, 16'h8000);
  endtask

  task automatic t_short;
    logic [15:0] rd;
    logic h;
    xfer(7'd3, 1'b0, 16'h1234, 23, rd, h);
    rd_chk("R6 short write ignored", 7'd3, 16'hA5C3);
    wr(7'd5, 16'h5A5A);
    rd_chk("R10 frame after abort", 7'd5, 16'h5A5A);
    xfer(7'd0, 1'b1, 16'h0000, 12, rd, h, 1'b1);
    cs_n = 1'b1;
    #10;
    check16("R5 sdout after aborted read", {15'd0, sdout}, 16'd0);
    #50;
  endtask

  task automatic t_long;
    logic [15:0] rd;
    logic h;
    xfer(7'd9, 1'b0, 16'h0F0F, 30, rd, h);
    rd_chk("R7 extra clocks ignored", 7'd9, 16'h0F0F);
  endtask

  task automatic t_range;
    wr(7'd4, 16'h1111);
    wr(7'd100, 16'hBEEF);
    rd_chk("R9 out-of-range reads 0", 7'd100, 16'h0000);
    rd_chk("R9 alias word untouched", 7'd4, 16'h1111);
  endtask

  task automatic t_read_only;
    logic [15:0] rd;
    logic h;
    xfer(7'd17, 1'b1, 16'hFFFF, 24, rd, h);
    check16("R11 read returns data", rd, 16'h8000);
    rd_chk("R11 read left word", 7'd17, 16'h8000);
  endtask

  task automatic t_reset_again;
    rst_n = 1'b0; #45; rst_n = 1'b1; #40;
    rd_chk("R8 cleared after reset", 7'd3, 16'h0000);
  endtask

  initial begin
    rst_n = 1'b1; cs_n = 1'b1; sclk = 1'b0; sdin = 1'b0;
    #5;
    t_reset();
    t_patterns();
    t_short();
    t_long();
    t_range();
    t_read_only();
    t_reset_again();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule